// File: doc/BRIEF.md
# Expansion-Area Packed Bank Mapper

This block is the banking logic of a game cartridge. One write-only control byte selects a 32 KB program-ROM page for the CPU window at $8000-$FFFF and an 8 KB pattern-ROM page for the video side at $0000-$1FFF. The register is decoded only loosely in the expansion area $4000-$5FFF. Any write there with address bits 14 and 8 both set reaches it, so it answers at many mirrored addresses.

The control byte packs both page numbers in a non-contiguous layout. The program page comes from bits 5:3. The pattern page comes from bits 2:0, with bit 6 added above them as its most significant bit. Bit 7 is not used. Each page number is cut down to the number of pages the fitted ROM holds before it is stored. The block then builds the ROM addresses and registers them. A fixed strap parameter chooses whether the nametable select line follows video address bit 10 or bit 11.

The mapper never drives the CPU data bus, so reads of its register address leave the bus floating. No work RAM or pattern RAM is fitted.

Top module: `exp_bank_mapper`

## Requirements
- R1: A write is accepted when cpu_wr and cpu_m2 are both high, cpu_addr lies in $4000-$5FFF, and cpu_addr bits 14 and 8 are both 1. Every such address responds, for example $4100, $41FF, $4F00, $5100 and $5FFF.
- R2: Writes to any other address leave both stored pages unchanged. Examples are $4000, $40FF, $4200, $5EFF, $6100, $7FFF, $C100, $0100 and $2100.
- R3: The program page is data bits 5:3, read as an unsigned number.
- R4: The pattern page is {data bit 6, data bits 2:0}, with bit 6 as the most significant bit.
- R5: Before it is stored, each page is ANDed with (ROM size / page size - 1). The page size is 32 KB for program ROM and 8 KB for pattern ROM.
- R6: prg_rom_addr equals {program page, cpu_addr[14:0]}, truncated to the width of the program ROM. prg_sel is cpu_addr bit 15.
- R7: chr_rom_addr equals {pattern page, ppu_addr[12:0]}, truncated to the width of the pattern ROM. chr_sel is high only when ppu_addr is below $2000.
- R8: Synchronous reset sets both pages to 0 and clears the registered outputs.
- R9: Data bit 7 has no effect on either page.
- R10: With MIRROR_VERT = 1, nt_a10 equals ppu_addr bit 10. With MIRROR_VERT = 0, it equals ppu_addr bit 11.
- R11: A write strobe without cpu_m2 high is ignored.
- R12: All address outputs are registered. They show the inputs and pages present at the preceding rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_m2 | input | 1 | CPU phase-2 qualifier |
| ppu_addr | input | 14 | Video address bus |
| prg_rom_addr | output | PRG_AW | Program ROM address |
| prg_sel | output | 1 | Program ROM window active |
| chr_rom_addr | output | CHR_AW | Pattern ROM address |
| chr_sel | output | 1 | Pattern ROM window active |
| nt_a10 | output | 1 | Nametable RAM address bit 10 from the strap |

## Verification
The bench builds two copies of the block that share the same stimulus. The first copy uses 64 KB program ROM, 64 KB pattern ROM and vertical strapping. Its masks drop data bits 4, 5 and 6, which exercises the size masking. The second copy uses 256 KB program ROM, 128 KB pattern ROM and horizontal strapping. This makes the full three-bit program field and the separated pattern bit from data bit 6 visible on the address outputs. All 256 data values are swept through both copies, and a list of matching and non-matching register addresses tests the partial decode.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

  localparam int PRG_FIELD_W = 3;
  localparam int CHR_FIELD_W = 4;
  localparam int PRG_OFS_W   = 15;
  localparam int CHR_OFS_W   = 13;

  typedef struct packed {
    logic [PRG_FIELD_W-1:0] prg;
    logic [CHR_FIELD_W-1:0] chr;
  } bank_pair_t;

  // Split the packed control byte; bit 7 takes no part.
  function automatic bank_pair_t split_ctrl(input logic [6:0] d);
    bank_pair_t r;
    r.prg = d[5:3];
    r.chr = {d[6], d[2:0]};
    return r;
  endfunction

endpackage

// File: rtl/bm_reg_decode.sv
module bm_reg_decode (
  input  logic [15:0] cpu_addr,
  input  logic        cpu_wr,
  input  logic        cpu_m2,
  output logic        hit
);
  logic in_exp_area;

  always_comb begin
    in_exp_area = (cpu_addr[15:13] == 3'b010);
    hit = cpu_wr && cpu_m2 && in_exp_area && cpu_addr[14] && cpu_addr[8];
  end
endmodule

// File: rtl/bm_bank_regs.sv
module bm_bank_regs
  import bankmap_pkg::*;
#(
  parameter int PRG_PAGES = 2,
  parameter int CHR_PAGES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   hit,
  input  logic [7:0]             cpu_data,
  output logic [PRG_FIELD_W-1:0] prg_bank,
  output logic [CHR_FIELD_W-1:0] chr_bank
);
  localparam logic [PRG_FIELD_W-1:0] PRG_MASK = PRG_FIELD_W'(PRG_PAGES - 1);
  localparam logic [CHR_FIELD_W-1:0] CHR_MASK = CHR_FIELD_W'(CHR_PAGES - 1);

  bank_pair_t fields;

  always_comb fields = split_ctrl(cpu_data[6:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      prg_bank <= '0;
      chr_bank <= '0;
    end else if (hit) begin
      prg_bank <= fields.prg & PRG_MASK;
      chr_bank <= fields.chr & CHR_MASK;
    end
  end

  // R8
  a_r8_reset_pages: assert property (@(posedge clk)
    rst |=> (prg_bank == '0 && chr_bank == '0));
  // R2
  a_r2_hold_without_hit: assert property (@(posedge clk) disable iff (rst)
    !hit |=> ($stable(prg_bank) && $stable(chr_bank)));
  // R3
  a_r3_prg_load: assert property (@(posedge clk) disable iff (rst)
    hit |=> prg_bank == ($past(cpu_data[5:3]) & PRG_MASK));
  // R4
  a_r4_chr_load: assert property (@(posedge clk) disable iff (rst)
    hit |=> chr_bank == ({$past(cpu_data[6]), $past(cpu_data[2:0])} & CHR_MASK));
endmodule

// File: rtl/bm_window_addr.sv
module bm_window_addr #(
  parameter int BANK_W = 3,
  parameter int OFS_W  = 15,
  parameter int OUT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] bank,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              in_window,
  output logic [OUT_W-1:0]  rom_addr,
  output logic              sel
);
  localparam int FULL_W = BANK_W + OFS_W;

  logic [FULL_W-1:0] full_addr;
  logic [OUT_W-1:0]  next_addr;

  always_comb full_addr = {bank, ofs};

  generate
    if (OUT_W <= FULL_W) begin : g_trunc
      always_comb next_addr = full_addr[OUT_W-1:0];
    end else begin : g_pad
      always_comb next_addr = {{(OUT_W-FULL_W){1'b0}}, full_addr};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr <= '0;
      sel      <= 1'b0;
    end else begin
      rom_addr <= next_addr;
      sel      <= in_window;
    end
  end

  // R12
  a_r12_offset_latency: assert property (@(posedge clk) disable iff (rst)
    !rst |=> rom_addr[OFS_W-1:0] == $past(ofs));
  // R12
  a_r12_sel_latency: assert property (@(posedge clk) disable iff (rst)
    !rst |=> sel == $past(in_window));
endmodule

// File: rtl/exp_bank_mapper.sv
module exp_bank_mapper
  import bankmap_pkg::*;
#(
  parameter int PRG_KB      = 64,
  parameter int CHR_KB      = 64,
  parameter bit MIRROR_VERT = 1'b1,
  localparam int PRG_AW     = $clog2(PRG_KB * 1024),
  localparam int CHR_AW     = $clog2(CHR_KB * 1024)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_data,
  input  logic              cpu_wr,
  input  logic              cpu_m2,
  input  logic [13:0]       ppu_addr,
  output logic [PRG_AW-1:0] prg_rom_addr,
  output logic              prg_sel,
  output logic [CHR_AW-1:0] chr_rom_addr,
  output logic              chr_sel,
  output logic              nt_a10
);
  localparam int PRG_PAGES = PRG_KB / 32;
  localparam int CHR_PAGES = CHR_KB / 8;

  logic                   reg_hit;
  logic [PRG_FIELD_W-1:0] prg_bank;
  logic [CHR_FIELD_W-1:0] chr_bank;

  bm_reg_decode u_decode (
    .cpu_addr (cpu_addr),
    .cpu_wr   (cpu_wr),
    .cpu_m2   (cpu_m2),
    .hit      (reg_hit)
  );

  bm_bank_regs #(
    .PRG_PAGES (PRG_PAGES),
    .CHR_PAGES (CHR_PAGES)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .hit      (reg_hit),
    .cpu_data (cpu_data),
    .prg_bank (prg_bank),
    .chr_bank (chr_bank)
  );

  bm_window_addr #(
    .BANK_W (PRG_FIELD_W),
    .OFS_W  (PRG_OFS_W),
    .OUT_W  (PRG_AW)
  ) u_prg_addr (
    .clk       (clk),
    .rst       (rst),
    .bank      (prg_bank),
    .ofs       (cpu_addr[14:0]),
    .in_window (cpu_addr[15]),
    .rom_addr  (prg_rom_addr),
    .sel       (prg_sel)
  );

  bm_window_addr #(
    .BANK_W (CHR_FIELD_W),
    .OFS_W  (CHR_OFS_W),
    .OUT_W  (CHR_AW)
  ) u_chr_addr (
    .clk       (clk),
    .rst       (rst),
    .bank      (chr_bank),
    .ofs       (ppu_addr[12:0]),
    .in_window (~ppu_addr[13]),
    .rom_addr  (chr_rom_addr),
    .sel       (chr_sel)
  );

  logic nt_next;

  generate
    if (MIRROR_VERT) begin : g_vert
      always_comb nt_next = ppu_addr[10];
    end else begin : g_horz
      always_comb nt_next = ppu_addr[11];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) nt_a10 <= 1'b0;
    else     nt_a10 <= nt_next;
  end

  // R10
  a_r10_strap: assert property (@(posedge clk) disable iff (rst)
    !rst |=> nt_a10 == (MIRROR_VERT ? $past(ppu_addr[10]) : $past(ppu_addr[11])));
  // R11
  a_r11_m2_gate: assert property (@(posedge clk) disable iff (rst)
    !cpu_m2 |=> ($stable(prg_bank) && $stable(chr_bank)));
  // R7
  a_r7_chr_window: assert property (@(posedge clk) disable iff (rst)
    !rst |=> chr_sel == !$past(ppu_addr[13]));
endmodule

// File: tb/exp_bank_mapper_test.sv
`timescale 1ns/1ps
module exp_bank_mapper_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic        cpu_wr = 1'b0;
  logic        cpu_m2 = 1'b0;
  logic [13:0] ppu_addr = 14'h0000;

  logic [15:0] p0;
  logic [15:0] c0;
  logic [17:0] p1;
  logic [16:0] c1;
  logic ps0, cs0, nt0, ps1, cs1, nt1;

  int vectors = 0;
  int errors = 0;
  bit done = 0;
  int cur = 0;

  always #2.5 clk = ~clk;

  exp_bank_mapper #(.PRG_KB(64), .CHR_KB(64), .MIRROR_VERT(1'b1)) uut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .cpu_m2(cpu_m2), .ppu_addr(ppu_addr),
    .prg_rom_addr(p0), .prg_sel(ps0), .chr_rom_addr(c0), .chr_sel(cs0), .nt_a10(nt0));

  exp_bank_mapper #(.PRG_KB(256), .CHR_KB(128), .MIRROR_VERT(1'b0)) uut_wide (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .cpu_m2(cpu_m2), .ppu_addr(ppu_addr),
    .prg_rom_addr(p1), .prg_sel(ps1), .chr_rom_addr(c1), .chr_sel(cs1), .nt_a10(nt1));

  function automatic int exp_prg(input int d, input int kb);
    return ((d >> 3) & 7) & (kb / 32 - 1);
  endfunction

  function automatic int exp_chr(input int d, input int kb);
    return ((d & 7) | ((d >> 3) & 8)) & (kb / 8 - 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic m2);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1; cpu_m2 = m2;
    @(posedge clk);
    @(negedge clk);
    cpu_wr = 1'b0; cpu_m2 = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [13:0] p);
    @(negedge clk);
    cpu_addr = a; ppu_addr = p;
    @(posedge clk);
    #1;
  endtask

  // Check every output of both copies against the model held in cur.
  task automatic verify(input int ofs, input int pa, input string req);
    int o = ofs & 16'h7FFF;
    rd(16'(16'h8000 | o), 14'(pa));
    chk({req, " R6 prg addr 64K"}, int'(p0), (exp_prg(cur, 64) * 32768 + o) & 16'hFFFF);
    chk({req, " R6 prg addr 256K"}, int'(p1), exp_prg(cur, 256) * 32768 + o);
    chk("R6 prg_sel", int'(ps0), 1);
    if (pa < 16'h2000) begin
      chk({req, " R7 chr addr 64K"}, int'(c0), (exp_chr(cur, 64) * 8192 + (pa & 16'h1FFF)) & 16'hFFFF);
      chk({req, " R7 chr addr 128K"}, int'(c1), exp_chr(cur, 128) * 8192 + (pa & 16'h1FFF));
    end
    chk("R7 chr_sel", int'(cs1), (pa < 16'h2000) ? 1 : 0);
    chk("R10 vertical strap", int'(nt0), (pa >> 10) & 1);
    chk("R10 horizontal strap", int'(nt1), (pa >> 11) & 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] hits [5] = '{16'h4100, 16'h41FF, 16'h4F00, 16'h5100, 16'h5FFF};
    logic [15:0] miss [9] = '{16'h4000, 16'h40FF, 16'h4200, 16'h5EFF, 16'h6100,
                               16'h7FFF, 16'hC100, 16'h0100, 16'h2100};
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset prg addr", int'(p1), 0);
    chk("R8 reset chr_sel", int'(cs0), 0);
    @(negedge clk);
    rst = 1'b0;

    // R8: pages written, then reset again, must be back to 0
    wr(16'h4100, 8'h7F, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    cur = 0;
    verify(16'h1234, 16'h0ABC, "R8");

    // R12: outputs change only at the clock edge
    wr(16'h4100, 8'h2A, 1'b1); cur = 8'h2A;
    verify(16'h0010, 16'h0020, "R12");
    @(negedge clk);
    cpu_addr = 16'hFFFF;
    #1;
    chk("R12 output held until edge", int'(p1), exp_prg(cur, 256) * 32768 + 16'h0010);

    // Sweep all data values: R3, R4, R5
    for (int d = 0; d < 256; d++) begin
      wr(16'h4100, 8'(d), 1'b1);
      cur = d & 8'h7F;
      verify((d * 37) & 16'h7FFF, (d * 53) & 16'h3FFF, "R3 R4 R5");
    end

    // R9: bit 7 set and clear give the same pages
    for (int d = 0; d < 128; d += 9) begin
      wr(16'h4100, 8'(d | 8'h80), 1'b1);
      cur = d;
      verify(16'h0100, 16'h0100, "R9");
    end

    // R1: every mirrored image responds
    foreach (hits[i]) begin
      wr(16'h4100, 8'h00, 1'b1);
      wr(hits[i], 8'h7F, 1'b1);
      cur = 8'h7F;
      verify(16'h0000, 16'h0000, "R1");
    end

    // R2: non-matching addresses are ignored
    foreach (miss[i]) begin
      wr(16'h4100, 8'h00, 1'b1);
      wr(miss[i], 8'h7F, 1'b1);
      cur = 0;
      verify(16'h0000, 16'h0000, "R2");
    end

    // R11: strobe without M2 ignored
    wr(16'h4100, 8'h15, 1'b1); cur = 8'h15;
    wr(16'h4100, 8'h6A, 1'b0);
    verify(16'h7FFF, 16'h1FFF, "R11");

    // R7, R10: nametable region is outside the pattern window
    verify(16'h0000, 16'h2400, "R7 R10");
    verify(16'h0000, 16'h2800, "R7 R10");
    verify(16'h0000, 16'h3C00, "R7 R10");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule